// File: doc/BRIEF.md
# Hot-swap fault retry controller

This block decides whether the gate of a hot-swap pass transistor may be on after overcurrent or hard-short events. It receives an overcurrent indication that has already been qualified, a millisecond tick, a retry-mode field, a retry-delay field, an active-low master reset and a configuration-write strobe. It drives the gate enable and a power-good permission. It also drives a retry counter, a sticky failed-after-retry status bit with an active-low pin, and an active-low overcurrent flag.

When a fault appears, the gate and power-good permission are withdrawn. The controller then waits a selectable number of ticks and re-enables the gate for a trial. A trial that stays fault-free for a short settle window returns to normal operation and clears the counter. A trial that sees the fault again counts one failed try. Once the count reaches the limit set by the mode, the block enters a lockout with the gate off. Only the master reset or the synchronous reset leaves the lockout. In the endless mode there is no lockout: the status bit is raised after the first failed try and trials go on.

Top module: `hsw_retry_ctrl`

## Requirements
- R1: After `rst` or a low `mr_n` is sampled, the outputs are gate_en=1, pg_enable=1, retry_cnt=0, far_stat=0, far_n=1 and foc_n=1.
- R2: When oc_fault is sampled high while the gate is enabled, gate_en and pg_enable are both 0 in the following cycle.
- R3: delay_sel values 0, 1, 2 and 3 select DLY_0, DLY_1, DLY_2 and DLY_3 ticks, with defaults of 100, 500, 1000 and 5000 one-millisecond ticks. The gate re-enables in the cycle after the last of those ticks is seen while waiting.
- R4: An oc_fault sampled high during a trial turns the gate off in the next cycle and raises retry_cnt by one. retry_cnt saturates at all ones.
- R5: retry_mode values 1 to 6 allow 1, 2, 4, 8, 16 and 32 failed tries. When retry_cnt reaches the limit, far_stat becomes 1 and far_n becomes 0. The gate then stays off regardless of ticks or of oc_fault.
- R6: With retry_mode 0, the first fault goes straight to lockout with far_stat=1, and retry_cnt stays 0.
- R7: With retry_mode 7 there is no lockout. far_stat is set after the first failed try, and trials continue for as long as the fault persists.
- R8: A trial with SETTLE_CYC consecutive fault-free cycles returns to gate_en=1, pg_enable=1 and retry_cnt=0.
- R9: mr_n low ends a lockout and clears far_stat, far_n, retry_cnt and foc_n to their R1 values in the next cycle.
- R10: foc_n goes low in the cycle after oc_fault is sampled high. It returns high only after cfg_wr is sampled while oc_fault is low. A cfg_wr while oc_fault is high leaves it low.
- R11: far_stat stays set through a successful trial in retry_mode 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_n | input | 1 | Master reset, active low, sampled synchronously |
| oc_fault | input | 1 | Qualified overcurrent / hard-short present |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| retry_mode | input | 3 | Retry limit select (0: none, 1..6: 2^(n-1), 7: endless) |
| delay_sel | input | 2 | Back-off delay select |
| cfg_wr | input | 1 | Configuration-register write strobe |
| gate_en | output | 1 | Gate drive enable |
| pg_enable | output | 1 | Power-good permission, low forces power-good outputs off |
| retry_cnt | output | CNT_W | Failed-try counter |
| far_stat | output | 1 | Sticky failed-after-retry status |
| far_n | output | 1 | Failed-after-retry pin, active low |
| foc_n | output | 1 | Overcurrent fault flag, active low |

## Verification
The bench builds the controller with delays of 3, 5, 7 and 10 ticks, a tick every third clock, a settle window of 4 cycles and a 6-bit counter. With these values every delay choice, a lockout, a recovery after a failed try, and counter saturation in the endless mode can all be reached within a few thousand cycles. A behavioural model predicts every output in every cycle. Directed checks confirm the delay length, the lockout's indifference to ticks and to a cleared fault, and the write-after-removal rule of the flag.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [1:0] {
    ST_ON   = 2'd0,
    ST_WAIT = 2'd1,
    ST_TRY  = 2'd2,
    ST_LOCK = 2'd3
  } hsw_state_e;

  localparam logic [2:0] MODE_NONE    = 3'd0;
  localparam logic [2:0] MODE_ENDLESS = 3'd7;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/hsw_tick_timer.sv
module hsw_tick_timer #(
  parameter int DLY_0 = 100,
  parameter int DLY_1 = 500,
  parameter int DLY_2 = 1000,
  parameter int DLY_3 = 5000
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       done
);
  localparam int DMAX = hsw_pkg::max4(DLY_0, DLY_1, DLY_2, DLY_3);
  localparam int TW   = $clog2(DMAX + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] last;

  always_comb begin
    case (sel)
      2'd0:    last = TW'(DLY_0 - 1);
      2'd1:    last = TW'(DLY_1 - 1);
      2'd2:    last = TW'(DLY_2 - 1);
      default: last = TW'(DLY_3 - 1);
    endcase
  end

  assign done = run && tick && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (clr || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hsw_settle_timer.sv
module hsw_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  input  logic fault,
  output logic done
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] cnt_q;

  assign done = run && !fault && (cnt_q == SW'(SETTLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (clr || !run || fault) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hsw_retry_policy.sv
module hsw_retry_policy #(
  parameter int CNT_W = 6
) (
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] cnt,
  output logic             endless,
  output logic             no_retry,
  output logic [CNT_W-1:0] cnt_bump,
  output logic             exhausted
);
  logic [CNT_W:0] limit;

  assign endless  = (mode == hsw_pkg::MODE_ENDLESS);
  assign no_retry = (mode == hsw_pkg::MODE_NONE);

  always_comb begin
    limit = '0;
    if (!endless && !no_retry) begin
      limit = {{CNT_W{1'b0}}, 1'b1} << (mode - 3'd1);
    end
  end

  assign cnt_bump  = (cnt == {CNT_W{1'b1}}) ? cnt : cnt + 1'b1;
  assign exhausted = !endless && ({1'b0, cnt_bump} >= limit);
endmodule

// File: rtl/hsw_oc_flag.sv
module hsw_oc_flag (
  input  logic clk,
  input  logic clr,
  input  logic oc,
  input  logic wr,
  output logic flag_n
);
  always_ff @(posedge clk) begin
    if (clr) begin
      flag_n <= 1'b1;
    end else if (oc) begin
      flag_n <= 1'b0;
    end else if (wr) begin
      flag_n <= 1'b1;
    end
  end
endmodule

// File: rtl/hsw_retry_ctrl.sv
module hsw_retry_ctrl #(
  parameter int CNT_W      = 6,
  parameter int DLY_0      = 100,
  parameter int DLY_1      = 500,
  parameter int DLY_2      = 1000,
  parameter int DLY_3      = 5000,
  parameter int SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mr_n,
  input  logic             oc_fault,
  input  logic             ms_tick,
  input  logic [2:0]       retry_mode,
  input  logic [1:0]       delay_sel,
  input  logic             cfg_wr,
  output logic             gate_en,
  output logic             pg_enable,
  output logic [CNT_W-1:0] retry_cnt,
  output logic             far_stat,
  output logic             far_n,
  output logic             foc_n
);
  import hsw_pkg::*;

  hsw_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             far_q, far_d;
  logic             clr;
  logic             dly_done, settle_done;
  logic             endless, no_retry, exhausted;
  logic [CNT_W-1:0] cnt_bump;

  assign clr = rst || !mr_n;

  hsw_tick_timer #(
    .DLY_0(DLY_0), .DLY_1(DLY_1), .DLY_2(DLY_2), .DLY_3(DLY_3)
  ) u_delay (
    .clk  (clk),
    .clr  (clr),
    .run  (st_q == ST_WAIT),
    .tick (ms_tick),
    .sel  (delay_sel),
    .done (dly_done)
  );

  hsw_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .clr   (clr),
    .run   (st_q == ST_TRY),
    .fault (oc_fault),
    .done  (settle_done)
  );

  hsw_retry_policy #(.CNT_W(CNT_W)) u_policy (
    .mode      (retry_mode),
    .cnt       (cnt_q),
    .endless   (endless),
    .no_retry  (no_retry),
    .cnt_bump  (cnt_bump),
    .exhausted (exhausted)
  );

  hsw_oc_flag u_flag (
    .clk    (clk),
    .clr    (clr),
    .oc     (oc_fault),
    .wr     (cfg_wr),
    .flag_n (foc_n)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    far_d = far_q;
    case (st_q)
      ST_ON: begin
        if (oc_fault) begin
          if (no_retry) begin
            st_d  = ST_LOCK;
            far_d = 1'b1;
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (dly_done) st_d = ST_TRY;
      end
      ST_TRY: begin
        if (oc_fault) begin
          cnt_d = cnt_bump;
          if (endless) begin
            far_d = 1'b1;
            st_d  = ST_WAIT;
          end else if (exhausted) begin
            far_d = 1'b1;
            st_d  = ST_LOCK;
          end else begin
            st_d = ST_WAIT;
          end
        end else if (settle_done) begin
          st_d  = ST_ON;
          cnt_d = '0;
        end
      end
      default: st_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      st_q      <= ST_ON;
      cnt_q     <= '0;
      far_q     <= 1'b0;
      gate_en   <= 1'b1;
      pg_enable <= 1'b1;
      far_n     <= 1'b1;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      far_q     <= far_d;
      gate_en   <= (st_d == ST_ON) || (st_d == ST_TRY);
      pg_enable <= (st_d == ST_ON);
      far_n     <= !far_d;
    end
  end

  assign retry_cnt = cnt_q;
  assign far_stat  = far_q;
endmodule

// File: rtl/hsw_retry_ctrl_chk.sv
module hsw_retry_ctrl_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             mr_n,
  input logic             oc_fault,
  input logic             cfg_wr,
  input logic             gate_en,
  input logic             pg_enable,
  input logic [CNT_W-1:0] retry_cnt,
  input logic             far_stat,
  input logic             foc_n
);
  a_r2_gate_drop: assert property (@(posedge clk) disable iff (rst || !mr_n)
    (oc_fault && gate_en) |=> (!gate_en && !pg_enable));

  a_r8_pg_needs_gate: assert property (@(posedge clk) disable iff (rst || !mr_n)
    pg_enable |-> gate_en);

  a_r4_cnt_step: assert property (@(posedge clk) disable iff (rst || !mr_n)
    (retry_cnt != $past(retry_cnt)) |->
      ((retry_cnt == $past(retry_cnt) + 1'b1) || (retry_cnt == '0)));

  a_r11_far_sticky: assert property (@(posedge clk) disable iff (rst || !mr_n)
    far_stat |=> far_stat);

  a_r10_foc_low: assert property (@(posedge clk) disable iff (rst || !mr_n)
    oc_fault |=> !foc_n);

  a_r10_foc_rise: assert property (@(posedge clk) disable iff (rst || !mr_n)
    $rose(foc_n) |-> (($past(cfg_wr) && !$past(oc_fault)) || $past(rst) || !$past(mr_n)));

  a_r9_mr_clear: assert property (@(posedge clk) disable iff (rst)
    !mr_n |=> (!far_stat && (retry_cnt == '0) && foc_n && gate_en));
endmodule

bind hsw_retry_ctrl hsw_retry_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mr_n      (mr_n),
  .oc_fault  (oc_fault),
  .cfg_wr    (cfg_wr),
  .gate_en   (gate_en),
  .pg_enable (pg_enable),
  .retry_cnt (retry_cnt),
  .far_stat  (far_stat),
  .foc_n     (foc_n)
);

// File: tb/hsw_retry_ctrl_tb.sv
`timescale 1ns/1ps
module hsw_retry_ctrl_tb;
  localparam int CW = 6, D0 = 3, D1 = 5, D2 = 7, D3 = 10, SC = 4, TP = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, mr_n = 1'b1, oc = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [2:0] mode = 3'd2;
  logic [1:0] sel = 2'd0;
  logic gate_en, pg_enable, far_stat, far_n, foc_n;
  logic [CW-1:0] retry_cnt;

  int n_chk = 0, n_bad = 0, tdiv = 0;
  bit cmp_on = 0, done_flag = 0;
  int m_st, m_tk, m_se, m_cnt, m_far, m_foc;

  always #10 clk = ~clk;

  hsw_retry_ctrl #(.CNT_W(CW), .DLY_0(D0), .DLY_1(D1), .DLY_2(D2), .DLY_3(D3),
                   .SETTLE_CYC(SC)) u_dut (
    .clk(clk), .rst(rst), .mr_n(mr_n), .oc_fault(oc), .ms_tick(tick),
    .retry_mode(mode), .delay_sel(sel), .cfg_wr(wr),
    .gate_en(gate_en), .pg_enable(pg_enable), .retry_cnt(retry_cnt),
    .far_stat(far_stat), .far_n(far_n), .foc_n(foc_n));

  function automatic int lim_of(input int m);
    return (m == 0) ? 0 : (1 << (m - 1));
  endfunction

  function automatic int dly_of(input int s);
    case (s)
      0: return D0;
      1: return D1;
      2: return D2;
      default: return D3;
    endcase
  endfunction

  // behavioural reference: 0 on, 1 waiting, 2 trial, 3 locked
  always @(posedge clk) begin
    if (rst || !mr_n) begin
      m_st = 0; m_tk = 0; m_se = 0; m_cnt = 0; m_far = 0; m_foc = 1;
    end else begin
      case (m_st)
        0: if (oc) begin
             if (mode == 0) begin m_st = 3; m_far = 1; end
             else begin m_st = 1; m_tk = 0; end
           end
        1: if (tick) begin
             m_tk++;
             if (m_tk == dly_of(int'(sel))) begin m_st = 2; m_se = 0; end
           end
        2: if (oc) begin
             if (m_cnt < CMAX) m_cnt++;
             if (mode == 7) begin m_far = 1; m_st = 1; m_tk = 0; end
             else if (m_cnt >= lim_of(int'(mode))) begin m_far = 1; m_st = 3; end
             else begin m_st = 1; m_tk = 0; end
           end else begin
             m_se++;
             if (m_se == SC) begin m_st = 0; m_cnt = 0; end
           end
        default: ;
      endcase
      if (oc) m_foc = 0;
      else if (wr) m_foc = 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2 gate_en model", int'(gate_en), (m_st == 0 || m_st == 2) ? 1 : 0);
      check("R2 pg_enable model", int'(pg_enable), (m_st == 0) ? 1 : 0);
      check("R4 retry_cnt model", int'(retry_cnt), m_cnt);
      check("R5 far_stat model", int'(far_stat), m_far);
      check("R5 far_n model", int'(far_n), 1 - m_far);
      check("R10 foc_n model", int'(foc_n), m_foc);
    end
  end

  always @(negedge clk) begin
    if (tdiv == TP - 1) begin tick <= 1'b1; tdiv = 0; end
    else begin tick <= 1'b0; tdiv++; end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic master_reset();
    mr_n <= 1'b0; step(1); mr_n <= 1'b1; step(1);
  endtask

  initial begin
    step(20000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t0;
    step(3);
    rst <= 1'b0;
    step(1);
    cmp_on = 1;
    // R1 reset values
    check("R1 gate_en", int'(gate_en), 1);
    check("R1 foc_n", int'(foc_n), 1);
    check("R1 far_n", int'(far_n), 1);
    check("R1 retry_cnt", int'(retry_cnt), 0);

    // limit of 2, shortest delay, fault held
    mode <= 3'd2; sel <= 2'd0; oc <= 1'b1;
    step(1);
    check("R2 gate off next cycle", int'(gate_en), 0);
    check("R2 pg off next cycle", int'(pg_enable), 0);
    step(120);
    check("R5 far_stat after limit", int'(far_stat), 1);
    check("R5 far_n low", int'(far_n), 0);
    check("R5 count at limit", int'(retry_cnt), 2);
    oc <= 1'b0;
    step(60);
    check("R5 locked gate off", int'(gate_en), 0);
    wr <= 1'b1; step(1); wr <= 1'b0; step(1);
    check("R10 foc_n after write", int'(foc_n), 1);

    // R9 master reset leaves lockout
    master_reset();
    check("R9 gate_en", int'(gate_en), 1);
    check("R9 far_n", int'(far_n), 1);
    check("R9 retry_cnt", int'(retry_cnt), 0);

    // R6 no retries
    mode <= 3'd0; oc <= 1'b1; step(1); oc <= 1'b0; step(50);
    check("R6 far_stat", int'(far_stat), 1);
    check("R6 gate stays off", int'(gate_en), 0);
    check("R6 retry_cnt", int'(retry_cnt), 0);
    master_reset();

    // R4 and R8: one failed try then recovery
    mode <= 3'd3; sel <= 2'd2; oc <= 1'b1;
    step(30); oc <= 1'b0; step(5);
    check("R4 one failed try", int'(retry_cnt), 1);
    step(60);
    check("R8 gate back on", int'(gate_en), 1);
    check("R8 pg back on", int'(pg_enable), 1);
    check("R8 count cleared", int'(retry_cnt), 0);
    check("R8 no status", int'(far_stat), 0);

    // R3 longest delay
    mode <= 3'd1; sel <= 2'd3; oc <= 1'b1; step(1); oc <= 1'b0;
    t0 = 1;
    while (!gate_en && t0 < 100) begin step(1); t0++; end
    check("R3 delay in range", (t0 >= D3 * TP - 2 && t0 <= D3 * TP + 3) ? 1 : 0, 1);
    step(10);
    master_reset();

    // R7 endless retries with the fault held
    mode <= 3'd7; sel <= 2'd1; oc <= 1'b1;
    step(40);
    check("R7 status after first failure", int'(far_stat), 1);
    check("R7 not locked count", (retry_cnt >= 1) ? 1 : 0, 1);
    wr <= 1'b1; step(1); wr <= 1'b0; step(1);
    check("R10 write during fault ignored", int'(foc_n), 0);
    step(1300);
    check("R7 counter saturated", int'(retry_cnt), CMAX);
    oc <= 1'b0;
    step(40);
    check("R7 gate on after clear", int'(gate_en), 1);
    check("R11 status kept", int'(far_stat), 1);
    check("R11 pin kept", int'(far_n), 0);
    step(5);
    finish_run();
  end
endmodule